// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the shifting core of an SPI master. It takes 8-bit words from an external transmit FIFO, shifts them out most-significant bit first on a serial data line, and captures the returning serial data into a word for an external receive FIFO. Every word sent produces exactly one received word. The serial clock is derived from the peripheral clock through an 8-bit divider: each half-period of the serial clock lasts DIV+1 peripheral cycles, so the serial rate is PCLK/(2*(DIV+1)).

The clock polarity and phase are fixed when the block is elaborated, through a mode parameter from 0 to 3, with mode 3 as the default. Up to eight active-low slave-select lines follow a select mask. By default a select line is driven only while a frame is being popped or shifted, and it releases as soon as the transmit FIFO has run dry. A hold parameter instead keeps each masked line asserted for as long as the engine is enabled. The divider is captured only while the engine is disabled and idle, so a running transfer never sees a rate change.

A surrounding controller starts a transfer by setting the mask and the divider, raising the enable, and filling the transmit FIFO. It collects received words on the push strobe.

Top module: `spi_serial_engine`

## Requirements
- R1: Each serial clock half-period lasts DIV+1 peripheral cycles. If the pop cycle is counted as cycle 0, `done` is high in cycle 16*(DIV+1)+1.
- R2: MOSI carries the popped word most-significant bit first. Each bit is valid at the sampling edge of the mode. SPI_MODE bit 1 is CPOL and bit 0 is CPHA. With CPHA=0 the data changes on trailing edges; with CPHA=1 it changes on leading edges.
- R3: MISO is sampled on the edge opposite to the one that updates MOSI and is assembled most-significant bit first. `rx_data` holds the complete word in the cycle where `rx_push` is high. `rx_push` pulses once per frame, in the same cycle as `done`.
- R4: While `busy` is low, `sclk` rests at the CPOL level. MOSI keeps the last bit it drove until the next pop.
- R5: `tx_pop` is high for one cycle, and only when `enable` is high, `busy` is low and `tx_empty` is low. One pop starts one frame.
- R6: `busy` is high from the cycle after the pop up to and including the cycle of the last serial clock edge. `done` is a one-cycle pulse in the first cycle in which `busy` is low again.
- R7: With HOLD_SEL=0, `ssel_n[i]` is 0 exactly when `sel_mask[i]` is 1 and either `busy` or `tx_pop` is high. Otherwise the line is 1, so the lines release once the FIFO is empty and the last frame has ended.
- R8: With HOLD_SEL=1, `ssel_n[i]` equals the inverse of `sel_mask[i]` whenever `enable` is high, whatever the frame state. All lines are 1 while `enable` is low.
- R9: `clk_div` is captured only while `enable` is low and `busy` is low. A change made while enabled has no effect on frame timing.
- R10: Lowering `enable` during a frame lets that frame complete with normal timing and data. No further pop happens while `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Engine enable |
| clk_div | input | 8 | Divider value DIV |
| sel_mask | input | 8 | Slave-select mask, one bit per line |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| tx_data | input | 8 | Head word of the transmit FIFO |
| tx_pop | output | 1 | Pops the transmit FIFO head |
| rx_data | output | 8 | Received word |
| rx_push | output | 1 | Pushes `rx_data` into the receive FIFO |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| ssel_n | output | 8 | Active-low slave selects |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench runs a mode-3 release-select engine beside a mode-0 hold-select engine. A bench slave model samples MOSI and drives MISO at the serial clock edges.

It measures frame length at DIV 0 and at DIV 255. A design with an off-by-one in the divider or in the edge count would finish a cycle early or late. A wrong bit order or a wrong sampling edge would return rotated or shifted words.

It runs back-to-back frames, where a release-mode select that dropped in the gap cycle would glitch the slave. It checks that a divider written while enabled is ignored, which a design that captured it anyway would show as a longer frame. It lowers `enable` mid-frame, where a design that aborted the frame would leave the word short.

// File: rtl/spi_eng_pkg.sv
// Package: types and mode decoding shared by the SPI master engine.
// Assumes the mode is an integer from 0 to 3: bit 1 is CPOL, bit 0 is CPHA.
package spi_eng_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } eng_state_t;

    // Clock polarity: the idle level of the serial clock.
    function automatic logic mode_cpol(input int mode);
        return ((mode / 2) % 2) == 1;
    endfunction

    // Clock phase: 1 means data changes on the leading edge.
    function automatic logic mode_cpha(input int mode);
        return (mode % 2) == 1;
    endfunction

endpackage

// File: rtl/spi_tick_gen.sv
// Module: half-period tick generator.
// Emits one tick every DIV+1 cycles while run is high.
// The divider is captured only while cfg_open is high.
// Assumes run stays high for the whole frame.
module spi_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_open,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // Capture the divider only while configuration is open.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (cfg_open) div_q <= div_in;
    end

    // Count cycles within a half-period; restart on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (tick)      cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == div_q);

endmodule

// File: rtl/spi_frame_shifter.sv
// Module: frame shifter.
// Generates the serial clock edges, shifts transmit bits out
// MSB first and shifts sampled receive bits in.
// Assumes load and tick never coincide.
// Assumes exactly 2*FRAME_W ticks follow each load.
module spi_frame_shifter #(
    parameter int FRAME_W = 8,
    parameter bit CPOL    = 1'b1,
    parameter bit CPHA    = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_data,
    input  logic               tick,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic [FRAME_W-1:0] rx_word,
    output logic               last_edge
);

    localparam int EDGES = 2 * FRAME_W;
    localparam int EW    = $clog2(EDGES);

    logic [EW-1:0]      edge_q;
    logic [FRAME_W-1:0] tx_q;
    logic [FRAME_W-1:0] rx_q;
    logic               leading;
    logic               shift_now;
    logic               sample_now;

    assign leading   = (edge_q[0] == 1'b0);
    assign last_edge = tick && (edge_q == EW'(EDGES - 1));

    // Pick the update and sample edges for the fixed phase.
    generate
        if (CPHA) begin : g_pha1
            assign shift_now  = tick && leading;
            assign sample_now = tick && !leading;
        end else begin : g_pha0
            assign shift_now  = tick && !leading && !last_edge;
            assign sample_now = tick && leading;
        end
    endgenerate

    // Edge counter and serial clock toggling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
            sclk   <= CPOL;
        end else if (load) begin
            edge_q <= '0;
            sclk   <= CPOL;
        end else if (tick) begin
            edge_q <= last_edge ? '0 : edge_q + 1'b1;
            sclk   <= ~sclk;
        end
    end

    // Transmit shift register and MOSI output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
            mosi <= 1'b0;
        end else if (load) begin
            if (!CPHA) begin
                mosi <= load_data[FRAME_W-1];
                tx_q <= {load_data[FRAME_W-2:0], 1'b0};
            end else begin
                tx_q <= load_data;
            end
        end else if (shift_now) begin
            mosi <= tx_q[FRAME_W-1];
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    // Receive shift register, filled MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)          rx_q <= '0;
        else if (sample_now) rx_q <= {rx_q[FRAME_W-2:0], miso};
    end

    assign rx_word = rx_q;

endmodule

// File: rtl/spi_sel_drive.sv
// Module: slave-select drivers.
// One active-low line per mask bit.
// Release mode follows frame activity; hold mode follows the enable.
// Purely combinational. Assumes mask and enable come from registers.
module spi_sel_drive #(
    parameter int NUM_SEL  = 8,
    parameter bit HOLD_SEL = 1'b0
) (
    input  logic [NUM_SEL-1:0] sel_mask,
    input  logic               enable,
    input  logic               frame_act,
    output logic [NUM_SEL-1:0] ssel_n
);

    logic act;

    // Choose the assertion condition for the configured select policy.
    generate
        if (HOLD_SEL) begin : g_hold
            assign act = enable;
        end else begin : g_release
            assign act = frame_act;
        end
    endgenerate

    // Drive each line low when it is masked in and the condition holds.
    generate
        for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
            assign ssel_n[i] = ~(sel_mask[i] & act);
        end
    endgenerate

endmodule

// File: rtl/spi_serial_engine.sv
// Module: SPI master serial engine (top).
// Pops words from a transmit FIFO and runs one frame per word.
// Pushes each received word with a done pulse.
// Assumes the FIFO presents valid tx_data whenever tx_empty is low.
// Assumes tx_pop is consumed in the cycle it is high.
module spi_serial_engine #(
    parameter int SPI_MODE = 3,
    parameter bit HOLD_SEL = 1'b0,
    parameter int FRAME_W  = 8,
    parameter int DIV_W    = 8,
    parameter int NUM_SEL  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic [NUM_SEL-1:0] sel_mask,
    input  logic               tx_empty,
    input  logic [FRAME_W-1:0] tx_data,
    output logic               tx_pop,
    output logic [FRAME_W-1:0] rx_data,
    output logic               rx_push,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic [NUM_SEL-1:0] ssel_n,
    output logic               busy,
    output logic               done
);

    import spi_eng_pkg::*;

    localparam bit CPOL = mode_cpol(SPI_MODE);
    localparam bit CPHA = mode_cpha(SPI_MODE);

    eng_state_t state_q;
    logic       tick;
    logic       last_edge;
    logic       done_q;

    assign busy   = (state_q == ST_RUN);
    assign tx_pop = (state_q == ST_IDLE) && enable && !tx_empty;

    // Frame sequencer: idle until a pop, run until the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (tx_pop)    state_q <= ST_RUN;
                ST_RUN:  if (last_edge) state_q <= ST_IDLE;
                default:                state_q <= ST_IDLE;
            endcase
        end
    end

    // End-of-frame pulse, one cycle after the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last_edge;
    end

    assign done    = done_q;
    assign rx_push = done_q;

    spi_tick_gen #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_open (!enable && !busy),
        .div_in   (clk_div),
        .run      (busy),
        .tick     (tick)
    );

    spi_frame_shifter #(
        .FRAME_W (FRAME_W),
        .CPOL    (CPOL),
        .CPHA    (CPHA)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_pop),
        .load_data (tx_data),
        .tick      (tick),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .rx_word   (rx_data),
        .last_edge (last_edge)
    );

    spi_sel_drive #(
        .NUM_SEL  (NUM_SEL),
        .HOLD_SEL (HOLD_SEL)
    ) u_sel (
        .sel_mask  (sel_mask),
        .enable    (enable),
        .frame_act (busy || tx_pop),
        .ssel_n    (ssel_n)
    );

endmodule

// File: rtl/spi_engine_checks.sv
// Module: protocol checker for the SPI master engine, bound to the top.
// Observes ports only.
module spi_engine_checks #(
    parameter int SPI_MODE = 3,
    parameter bit HOLD_SEL = 1'b0,
    parameter int NUM_SEL  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic [NUM_SEL-1:0] sel_mask,
    input logic               tx_pop,
    input logic               sclk,
    input logic               mosi,
    input logic [NUM_SEL-1:0] ssel_n,
    input logic               busy,
    input logic               done
);

    localparam bit CPOL = spi_eng_pkg::mode_cpol(SPI_MODE);

    // R5: a pop starts a frame in the next cycle.
    assert_pop_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> busy);

    // R6: done never lasts more than one cycle.
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the end of busy coincides with done.
    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R4: the serial clock rests at CPOL while idle.
    assert_idle_sclk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == CPOL));

    // R4: MOSI holds while idle and not popping.
    assert_idle_mosi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_pop) |=> $stable(mosi));

    generate
        if (HOLD_SEL) begin : g_hold_chk
            // R8: held selects follow the mask while enabled.
            assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                enable |-> (ssel_n == ~sel_mask));
        end else begin : g_rel_chk
            // R7: released selects are all high outside a frame.
            assert_sel_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!busy && !tx_pop) |-> (ssel_n == {NUM_SEL{1'b1}}));
        end
    endgenerate

endmodule

bind spi_serial_engine spi_engine_checks #(
    .SPI_MODE (SPI_MODE),
    .HOLD_SEL (HOLD_SEL),
    .NUM_SEL  (NUM_SEL)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .sel_mask (sel_mask),
    .tx_pop   (tx_pop),
    .sclk     (sclk),
    .mosi     (mosi),
    .ssel_n   (ssel_n),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_spi_serial_engine.sv
`timescale 1ns/1ps
// Bench: a mode-3 release-select engine (dut) and a mode-0 hold-select
// engine (dut_m0) share stimulus. Each has its own slave model.
module tb_spi_serial_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] clk_div = 8'd0;
    logic [7:0] sel_mask = 8'd0;
    logic       tx_empty = 1'b1;
    logic [7:0] tx_data = 8'd0;
    logic [7:0] pat = 8'd0;

    logic       tx_pop_a, rx_push_a, sclk_a, mosi_a, busy_a, done_a;
    logic [7:0] rx_data_a, ssel_n_a;
    logic       miso_a = 1'b0;
    logic       tx_pop_b, rx_push_b, sclk_b, mosi_b, busy_b, done_b;
    logic [7:0] rx_data_b, ssel_n_b;
    logic       miso_b = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spi_serial_engine #(.SPI_MODE(3), .HOLD_SEL(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_div(clk_div),
        .sel_mask(sel_mask), .tx_empty(tx_empty), .tx_data(tx_data),
        .tx_pop(tx_pop_a), .rx_data(rx_data_a), .rx_push(rx_push_a),
        .miso(miso_a), .sclk(sclk_a), .mosi(mosi_a), .ssel_n(ssel_n_a),
        .busy(busy_a), .done(done_a));

    spi_serial_engine #(.SPI_MODE(0), .HOLD_SEL(1'b1)) dut_m0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_div(clk_div),
        .sel_mask(sel_mask), .tx_empty(tx_empty), .tx_data(tx_data),
        .tx_pop(tx_pop_b), .rx_data(rx_data_b), .rx_push(rx_push_b),
        .miso(miso_b), .sclk(sclk_b), .mosi(mosi_b), .ssel_n(ssel_n_b),
        .busy(busy_b), .done(done_b));

    // Slave models: capture MOSI on rising sclk, present next MISO bit after it.
    logic [7:0] mcap_a = 8'd0, mcap_b = 8'd0;
    logic       sprev_a = 1'b1, sprev_b = 1'b0;
    int         scnt_a = 0, scnt_b = 0;

    always @(posedge clk) begin
        sprev_a <= sclk_a;
        if (sclk_a && !sprev_a) begin
            mcap_a <= {mcap_a[6:0], mosi_a};
            scnt_a <= scnt_a + 1;
            if (scnt_a < 7) miso_a <= pat[6 - scnt_a];
        end
        if (tx_pop_a) begin
            scnt_a <= 0;
            miso_a <= pat[7];
        end
    end

    always @(posedge clk) begin
        sprev_b <= sclk_b;
        if (sclk_b && !sprev_b) begin
            mcap_b <= {mcap_b[6:0], mosi_b};
            scnt_b <= scnt_b + 1;
            if (scnt_b < 7) miso_b <= pat[6 - scnt_b];
        end
        if (tx_pop_b) begin
            scnt_b <= 0;
            miso_b <= pat[7];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Waits for done on dut; returns cycles counted from the pop cycle.
    task automatic wait_done(output int k);
        k = 1;
        while (!done_a && k < 6000) begin
            @(negedge clk);
            k++;
        end
    endtask

    // {tx word, slave pattern, divider, select mask}
    localparam logic [31:0] VECS [0:4] = '{
        {8'hA5, 8'h3C, 8'd0,   8'h01},
        {8'h01, 8'h80, 8'd1,   8'h02},
        {8'hFF, 8'h00, 8'd2,   8'h80},
        {8'h6E, 8'hD9, 8'd3,   8'hA5},
        {8'h80, 8'h01, 8'd255, 8'h10}
    };

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk(sclk_a == 1'b1, "R4 reset sclk mode3", sclk_a, 1);
        chk(sclk_b == 1'b0, "R4 reset sclk mode0", sclk_b, 0);
        chk(!busy_a && !done_a && !tx_pop_a, "R6 reset idle", {busy_a, done_a, tx_pop_a}, 0);
        chk(ssel_n_a == 8'hFF && ssel_n_b == 8'hFF, "R7 reset selects",
            {ssel_n_a, ssel_n_b}, 16'hFFFF);

        // Table walk: one frame per vector on both engines
        for (int v = 0; v < 5; v++) begin
            logic [7:0] tx, pt, dv, mk;
            {tx, pt, dv, mk} = VECS[v];
            enable = 1'b0; clk_div = dv; sel_mask = mk; pat = pt;
            @(negedge clk);
            enable = 1'b1; tx_data = tx; tx_empty = 1'b0;
            #1;
            chk(tx_pop_a && tx_pop_b, "R5 pop when enabled", {tx_pop_a, tx_pop_b}, 2'b11);
            chk(ssel_n_a == ~mk, "R7 select at pop", ssel_n_a, ~mk);
            @(negedge clk);
            tx_empty = 1'b1;
            chk(busy_a && busy_b, "R6 busy after pop", {busy_a, busy_b}, 2'b11);
            wait_done(k);
            chk(k == 16 * (dv + 1) + 1, "R1 frame length", k, 16 * (dv + 1) + 1);
            chk(done_b, "R1 mode0 frame length", done_b, 1);
            chk(rx_push_a && rx_data_a == pt, "R3 rx word mode3", rx_data_a, pt);
            chk(rx_push_b && rx_data_b == pt, "R3 rx word mode0", rx_data_b, pt);
            chk(!busy_a, "R6 busy low at done", busy_a, 0);
            chk(ssel_n_a == 8'hFF, "R7 release when empty", ssel_n_a, 8'hFF);
            chk(ssel_n_b == ~mk, "R8 hold while enabled", ssel_n_b, ~mk);
            @(negedge clk);
            chk(!done_a && !rx_push_a, "R6 done single cycle", done_a, 0);
            chk(mcap_a == tx, "R2 mosi word mode3", mcap_a, tx);
            chk(mcap_b == tx, "R2 mosi word mode0", mcap_b, tx);
            repeat (3) @(negedge clk);
            chk(mosi_a == tx[0] && mosi_b == tx[0], "R4 mosi holds last bit",
                {mosi_a, mosi_b}, {tx[0], tx[0]});
            chk(sclk_a == 1'b1 && sclk_b == 1'b0, "R4 idle sclk", {sclk_a, sclk_b}, 2'b10);
        end

        // R5: no pop while disabled
        enable = 1'b0; tx_data = 8'h5A; tx_empty = 1'b0;
        repeat (3) @(negedge clk);
        chk(!tx_pop_a && !busy_a, "R5 no pop when disabled", {tx_pop_a, busy_a}, 0);
        chk(ssel_n_b == 8'hFF, "R8 hold released when disabled", ssel_n_b, 8'hFF);
        tx_empty = 1'b1;

        // R9: divider written while enabled is ignored
        clk_div = 8'd1; sel_mask = 8'h01; pat = 8'hC3;
        @(negedge clk);
        enable = 1'b1; clk_div = 8'd7;
        @(negedge clk);
        tx_data = 8'h3A; tx_empty = 1'b0;
        @(negedge clk);
        tx_empty = 1'b1;
        wait_done(k);
        chk(k == 33, "R9 divider frozen", k, 33);
        chk(rx_data_a == 8'hC3, "R9 data with frozen divider", rx_data_a, 8'hC3);

        // R10: enable dropped mid-frame
        @(negedge clk);
        enable = 1'b0; clk_div = 8'd0;
        @(negedge clk);
        enable = 1'b1; pat = 8'h96; tx_data = 8'h4B; tx_empty = 1'b0;
        @(negedge clk);
        tx_empty = 1'b0; tx_data = 8'h11;
        repeat (2) @(negedge clk);
        enable = 1'b0;
        k = 3;
        while (!done_a && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk(k == 17, "R10 frame completes", k, 17);
        chk(rx_data_a == 8'h96, "R10 rx word", rx_data_a, 8'h96);
        @(negedge clk);
        chk(!tx_pop_a && !busy_a, "R10 no pop after disable", {tx_pop_a, busy_a}, 0);
        chk(mcap_a == 8'h4B, "R10 mosi word", mcap_a, 8'h4B);
        tx_empty = 1'b1;

        // R7: back-to-back frames keep select asserted in the gap cycle
        sel_mask = 8'h04; pat = 8'h5C;
        @(negedge clk);
        enable = 1'b1; tx_data = 8'hE1; tx_empty = 1'b0;
        @(negedge clk);
        tx_data = 8'h1E;
        wait_done(k);
        chk(rx_data_a == 8'h5C, "R3 first back-to-back word", rx_data_a, 8'h5C);
        chk(tx_pop_a == 1'b1, "R5 pop in gap cycle", tx_pop_a, 1);
        chk(ssel_n_a == 8'hFB, "R7 select held across gap", ssel_n_a, 8'hFB);
        pat = 8'hA7;
        @(negedge clk);
        tx_empty = 1'b1;
        wait_done(k);
        chk(k == 17, "R1 second frame length", k, 17);
        chk(rx_data_a == 8'hA7, "R3 second back-to-back word", rx_data_a, 8'hA7);
        @(negedge clk);
        chk(mcap_a == 8'h1E, "R2 second mosi word", mcap_a, 8'h1E);
        chk(ssel_n_a == 8'hFF, "R7 release after drain", ssel_n_a, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule